// File: doc/BRIEF.md
# Trigger Routing Output Group

This block drives a small group of trigger outputs. Each output takes one line from a shared bank of input triggers, selected by an 8-bit field in that output's control register. The chosen line can be inverted, and is then shaped in one of two ways:

- **Level mode:** the line is passed straight through.
- **Pulse mode:** the line is resynchronised into the consumer's clock and each rising edge becomes a two-cycle pulse.

A per-output freeze enable makes the output hold low while an external debug-halt signal is high.

Software programs the group through a plain register port on the system clock. A write carries the group number of its target output in the address and the group number of its source in the data. The write only lands when both match the block's own group number.

The pulse shaper is a three-state machine per output, running on the consumer clock:

- **PS_IDLE:** no pulse.
  - Moves to PS_FIRST when a synchronised rising edge is seen.
  - Stays in PS_IDLE otherwise.
- **PS_FIRST:** first pulse cycle.
  - Moves to PS_SECOND if no new edge is seen.
  - Moves back to PS_FIRST (restart) if a new edge is seen.
- **PS_SECOND:** second pulse cycle.
  - Moves to PS_IDLE if no new edge is seen.
  - Moves to PS_FIRST (restart) if a new edge is seen.
- **Any state:** moves to PS_IDLE whenever the output is in level mode.

Top module: `trigmux_group`

## Requirements

- R1: After reset, every control register reads back with select 0, invert 0, pulse mode 0 and freeze 0. The group field (read bits 11:8) shows GROUP_ID, so with defaults each output reads 32'h0000_0300.

- R2: A write is accepted when all three conditions hold:
  - wr_addr[11:8] equals GROUP_ID;
  - wr_addr[7:0] is below NUM_OUT;
  - wr_data[11:8] equals GROUP_ID.

  An accepted write stores select = wr_data[7:0], invert = wr_data[16], pulse mode = wr_data[17] and freeze = wr_data[18] on the next clk edge. A read returns them at the same bit positions through a combinational rd_data.

- R3: A write whose source group, target group or target index fails those checks leaves every register unchanged. A read of a foreign group or of an index at or above NUM_OUT returns 0.

- R4: In level mode, trig_out[i] equals the selected trig_in bit XOR invert, with no clock delay. A select at or above NUM_IN reads as input 0 before inversion.

- R5: In pulse mode, a rising edge of the selected, inverted line raises trig_out[i] on the third cons_clk edge after the line changes. The output then stays high for exactly two cons_clk cycles, however long the line is held high.

- R6: An edge detected while a pulse is in progress restarts the pulse. Raw samples 1, 0, 1 on consecutive cons_clk edges give one unbroken high of four cycles.

- R7: frz_we with a matching target group and index stores frz_val into freeze bit 18 only. Select, invert and mode are unchanged. A frz_we to a foreign group has no effect.

- R8: While an output's freeze bit is set and dbg_halt is high, that output is 0. Outputs without freeze, or any output with dbg_halt low, behave normally.

- R9: In pulse mode, a falling edge of the shaped line gives no pulse. With invert set, a falling edge of the raw input gives a pulse.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset, register domain |
| wr_en | input | 1 | Full control write strobe |
| frz_we | input | 1 | Freeze-bit-only write strobe |
| frz_val | input | 1 | Value written by frz_we |
| wr_addr | input | 12 | Write target: [11:8] group, [7:0] output index |
| wr_data | input | 32 | Write data: [7:0] select, [11:8] source group, [16] invert, [17] pulse mode, [18] freeze |
| rd_addr | input | 12 | Read target: [11:8] group, [7:0] output index |
| rd_data | output | 32 | Combinational readback |
| cons_clk | input | 1 | Consumer clock for the pulse shapers |
| cons_rst_n | input | 1 | Active-low asynchronous reset, consumer domain |
| dbg_halt | input | 1 | Debug halt request |
| trig_in | input | NUM_IN | Input trigger bank |
| trig_out | output | NUM_OUT | Shaped trigger outputs |

## Verification

The timing each check relies on is as follows:

- **Register writes:** visible on rd_data right after the clk edge that takes them, since the read path has no register.
- **Level-mode outputs:** follow trig_in and dbg_halt combinationally, within the same cycle.
- **Pulse-mode outputs:** rise on the third cons_clk edge after the line changes, then hold for two cycles, or four on a restart.

The bench keeps a behavioural model with the same latencies and compares every output at each cons_clk falling edge. All stimulus changes on odd time units, so it never lands on a consumer clock edge. Pulse widths are also measured directly by counting high cycles in a fixed window.

// File: rtl/trigmux_pkg.sv
package trigmux_pkg;

    // bit positions of the control word on the register port
    localparam int SEL_W     = 8;
    localparam int GRP_LSB   = 8;
    localparam int GRP_W     = 4;
    localparam int INV_BIT   = 16;
    localparam int MODE_BIT  = 17;
    localparam int FRZ_BIT   = 18;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int SEL_SPACE = 1 << SEL_W;

    typedef struct packed {
        logic             frz;
        logic             pulse_md;
        logic             inv;
        logic [SEL_W-1:0] sel;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_FIRST  = 2'd1,
        PS_SECOND = 2'd2
    } pulse_st_e;

endpackage

// File: rtl/trigmux_regs.sv
module trigmux_regs
    import trigmux_pkg::*;
#(
    parameter int               NUM_OUT  = 4,
    parameter logic [GRP_W-1:0] GROUP_ID = 4'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              frz_we,
    input  logic              frz_val,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output chan_cfg_t         cfg_o [NUM_OUT]
);

    localparam int               IDX_W     = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
    localparam logic [SEL_W-1:0] NUM_OUT_B = SEL_W'(NUM_OUT);
    localparam int               FLD_W     = CFG_W - 1;

    chan_cfg_t cfg_q [NUM_OUT];

    logic wr_hit;
    logic src_ok;
    logic rd_hit;
    logic unused_wr_bits;

    assign wr_hit = (wr_addr[GRP_LSB +: GRP_W] == GROUP_ID) && (wr_addr[SEL_W-1:0] < NUM_OUT_B);
    assign src_ok = (wr_data[GRP_LSB +: GRP_W] == GROUP_ID);
    assign rd_hit = (rd_addr[GRP_LSB +: GRP_W] == GROUP_ID) && (rd_addr[SEL_W-1:0] < NUM_OUT_B);
    assign unused_wr_bits = ^{wr_data[DATA_W-1:FRZ_BIT+1], wr_data[INV_BIT-1:GRP_LSB+GRP_W]};

    logic [NUM_OUT*CFG_W-1:0] cfg_flat;
    logic [NUM_OUT*FLD_W-1:0] fld_flat;

    for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_chan
        logic idx_match;
        assign idx_match = (wr_addr[SEL_W-1:0] == SEL_W'(gi));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[gi] <= '0;
            end else if (wr_en && wr_hit && src_ok && idx_match) begin
                cfg_q[gi].sel      <= wr_data[SEL_W-1:0];
                cfg_q[gi].inv      <= wr_data[INV_BIT];
                cfg_q[gi].pulse_md <= wr_data[MODE_BIT];
                cfg_q[gi].frz      <= wr_data[FRZ_BIT];
            end else if (!wr_en && frz_we && wr_hit && idx_match) begin
                cfg_q[gi].frz <= frz_val;
            end
        end

        assign cfg_o[gi] = cfg_q[gi];
        assign cfg_flat[gi*CFG_W +: CFG_W] = cfg_q[gi];
        assign fld_flat[gi*FLD_W +: FLD_W] = {cfg_q[gi].pulse_md, cfg_q[gi].inv, cfg_q[gi].sel};
    end

    always_comb begin
        rd_data = '0;
        if (rd_hit) begin
            rd_data[SEL_W-1:0]         = cfg_q[rd_addr[IDX_W-1:0]].sel;
            rd_data[GRP_LSB +: GRP_W]  = GROUP_ID;
            rd_data[INV_BIT]           = cfg_q[rd_addr[IDX_W-1:0]].inv;
            rd_data[MODE_BIT]          = cfg_q[rd_addr[IDX_W-1:0]].pulse_md;
            rd_data[FRZ_BIT]           = cfg_q[rd_addr[IDX_W-1:0]].frz;
        end
    end

    AST_FOREIGN_SRC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !frz_we && (wr_data[GRP_LSB +: GRP_W] != GROUP_ID)) |=> $stable(cfg_flat)); // R3

    AST_FOREIGN_DST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || frz_we) && (wr_addr[GRP_LSB +: GRP_W] != GROUP_ID)) |=> $stable(cfg_flat)); // R3

    AST_FRZ_WRITE_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_we && !wr_en) |=> $stable(fld_flat)); // R7

endmodule

// File: rtl/trigmux_pulse_fsm.sv
module trigmux_pulse_fsm
    import trigmux_pkg::*;
(
    input  logic cons_clk,
    input  logic cons_rst_n,
    input  logic pulse_md,
    input  logic line_in,
    output logic pulse_o
);

    logic      s_meta;
    logic      s_sync;
    logic      s_prev;
    logic      edge_det;
    pulse_st_e state_q;
    pulse_st_e state_d;

    always_ff @(posedge cons_clk or negedge cons_rst_n) begin
        if (!cons_rst_n) begin
            s_meta <= 1'b0;
            s_sync <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s_meta <= line_in;
            s_sync <= s_meta;
            s_prev <= s_sync;
        end
    end

    assign edge_det = s_sync & ~s_prev;

    // state register
    always_ff @(posedge cons_clk or negedge cons_rst_n) begin
        if (!cons_rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = PS_IDLE;
        if (pulse_md) begin
            unique case (state_q)
                PS_IDLE:   state_d = edge_det ? PS_FIRST : PS_IDLE;
                PS_FIRST:  state_d = edge_det ? PS_FIRST : PS_SECOND;
                PS_SECOND: state_d = edge_det ? PS_FIRST : PS_IDLE;
                default:   state_d = PS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PS_FIRST:  pulse_o = 1'b1;
            PS_SECOND: pulse_o = 1'b1;
            default:   pulse_o = 1'b0;
        endcase
    end

    AST_EDGE_STARTS_PULSE: assert property (@(posedge cons_clk) disable iff (!cons_rst_n)
        (pulse_md && edge_det) |=> pulse_o); // R5

    AST_PULSE_MIN_TWO: assert property (@(posedge cons_clk) disable iff (!cons_rst_n)
        (pulse_md && $rose(pulse_o)) |=> pulse_o); // R5

    AST_LEVEL_KEEPS_IDLE: assert property (@(posedge cons_clk) disable iff (!cons_rst_n)
        !pulse_md |=> !pulse_o); // R4

    AST_LONG_PULSE_NEEDS_RESTART: assert property (@(posedge cons_clk) disable iff (!cons_rst_n)
        (pulse_md && pulse_o && $past(pulse_o) && $past(pulse_o, 2))
            |-> ($past(edge_det) || $past(edge_det, 2))); // R6

endmodule

// File: rtl/trigmux_group.sv
module trigmux_group
    import trigmux_pkg::*;
#(
    parameter int               NUM_OUT  = 4,
    parameter int               NUM_IN   = 16,
    parameter logic [GRP_W-1:0] GROUP_ID = 4'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              frz_we,
    input  logic              frz_val,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cons_clk,
    input  logic              cons_rst_n,
    input  logic              dbg_halt,
    input  logic [NUM_IN-1:0] trig_in,
    output logic [NUM_OUT-1:0] trig_out
);

    chan_cfg_t            cfg [NUM_OUT];
    logic [SEL_SPACE-1:0] in_ext;

    trigmux_regs #(
        .NUM_OUT  (NUM_OUT),
        .GROUP_ID (GROUP_ID)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .frz_we  (frz_we),
        .frz_val (frz_val),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg_o   (cfg)
    );

    // selects beyond the bank read as 0
    always_comb begin
        in_ext = '0;
        in_ext[NUM_IN-1:0] = trig_in;
    end

    for (genvar go = 0; go < NUM_OUT; go++) begin : g_out
        logic shaped;
        logic pulse;
        logic frozen;

        assign shaped = in_ext[cfg[go].sel] ^ cfg[go].inv;
        assign frozen = cfg[go].frz & dbg_halt;

        trigmux_pulse_fsm u_pulse (
            .cons_clk   (cons_clk),
            .cons_rst_n (cons_rst_n),
            .pulse_md   (cfg[go].pulse_md),
            .line_in    (shaped),
            .pulse_o    (pulse)
        );

        always_comb begin
            if (frozen) begin
                trig_out[go] = 1'b0;
            end else if (cfg[go].pulse_md) begin
                trig_out[go] = pulse;
            end else begin
                trig_out[go] = shaped;
            end
        end
    end

endmodule

// File: tb/trigmux_group_bench.sv
module trigmux_group_bench;

    localparam int CLK_PERIOD  = 10;
    localparam int CONS_PERIOD = 16;
    localparam int NO = 4;
    localparam int NI = 16;

    logic        clk = 1'b0;
    logic        cclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        frz_we = 1'b0;
    logic        frz_val = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        dbg_halt = 1'b0;
    logic [NI-1:0] trig_in = '0;
    logic [NO-1:0] trig_out;

    int    checks = 0;
    int    fails = 0;
    bit    run_cmp = 1'b0;
    string cmp_tag = "R1";

    int m_sel [NO];
    bit m_inv [NO];
    bit m_edg [NO];
    bit m_frz [NO];
    int cnt   [NO];
    bit h0 [NO];
    bit h1 [NO];
    bit h2 [NO];

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(CONS_PERIOD/2) cclk = ~cclk;

    trigmux_group u_trigmux_group (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .frz_we     (frz_we),
        .frz_val    (frz_val),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .cons_clk   (cclk),
        .cons_rst_n (crst_n),
        .dbg_halt   (dbg_halt),
        .trig_in    (trig_in),
        .trig_out   (trig_out)
    );

    function automatic bit raw_of(int i);
        bit b;
        b = (m_sel[i] < NI) ? trig_in[m_sel[i]] : 1'b0;
        return b ^ m_inv[i];
    endfunction

    // reference model, consumer domain
    always @(posedge cclk) begin
        for (int i = 0; i < NO; i++) begin
            if (!crst_n) begin
                cnt[i] = 0; h0[i] = 0; h1[i] = 0; h2[i] = 0;
            end else begin
                if (!m_edg[i]) cnt[i] = 0;
                else if (h1[i] && !h2[i]) cnt[i] = 2;
                else if (cnt[i] > 0) cnt[i] = cnt[i] - 1;
                h2[i] = h1[i];
                h1[i] = h0[i];
                h0[i] = raw_of(i);
            end
        end
    end

    // per-cycle comparison
    always @(negedge cclk) begin
        if (run_cmp) begin
            for (int i = 0; i < NO; i++) begin
                bit exp;
                if (m_frz[i] && dbg_halt) exp = 1'b0;
                else if (m_edg[i]) exp = (cnt[i] > 0);
                else exp = raw_of(i);
                checks++;
                if (trig_out[i] !== exp) begin
                    fails++;
                    $display("FAIL %s trig_out[%0d] got %b expected %b at %0t", cmp_tag, i, trig_out[i], exp, $time);
                end
            end
        end
    end

    task automatic do_write(input [3:0] grp, input [7:0] idx, input [3:0] sgrp,
                            input [7:0] sel, input bit inv, input bit edg, input bit frz);
        @(negedge clk); #1;
        wr_en = 1'b1;
        wr_addr = {grp, idx};
        wr_data = 32'({frz, edg, inv, 4'h0, sgrp, sel});
        @(posedge clk);
        if (grp == 4'd3 && idx < NO && sgrp == 4'd3) begin
            m_sel[idx] = sel; m_inv[idx] = inv; m_edg[idx] = edg; m_frz[idx] = frz;
        end
        #1 wr_en = 1'b0;
    endtask

    task automatic do_frz(input [3:0] grp, input [7:0] idx, input bit v);
        @(negedge clk); #1;
        frz_we = 1'b1; frz_val = v; wr_addr = {grp, idx};
        @(posedge clk);
        if (grp == 4'd3 && idx < NO) m_frz[idx] = v;
        #1 frz_we = 1'b0;
    endtask

    task automatic rd_check(input [11:0] a, input [31:0] exp, input string tag);
        @(negedge clk); #1;
        rd_addr = a;
        #2;
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s read %h got %h expected %h", tag, a, rd_data, exp);
        end
    endtask

    task automatic bit_check(input int ch, input bit exp, input string tag);
        #2;
        checks++;
        if (trig_out[ch] !== exp) begin
            fails++;
            $display("FAIL %s trig_out[%0d] got %b expected %b", tag, ch, trig_out[ch], exp);
        end
    endtask

    task automatic set_in(input int b, input bit v);
        @(negedge cclk); #1;
        trig_in[b] = v;
    endtask

    task automatic width_check(input int ch, input int ncyc, input int exp, input string tag);
        int n = 0;
        repeat (ncyc) begin
            @(negedge cclk);
            if (trig_out[ch]) n++;
        end
        checks++;
        if (n !== exp) begin
            fails++;
            $display("FAIL %s trig_out[%0d] high cycles got %0d expected %0d", tag, ch, n, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NO; i++) begin
            m_sel[i] = 0; m_inv[i] = 0; m_edg[i] = 0; m_frz[i] = 0;
        end
        #41;
        rst_n = 1'b1;
        crst_n = 1'b1;
        run_cmp = 1'b1;

        // R1 reset state
        cmp_tag = "R1";
        for (int i = 0; i < NO; i++) rd_check({4'd3, 8'(i)}, 32'h0000_0300, "R1");

        // R2 accepted writes
        cmp_tag = "R2";
        do_write(4'd3, 8'd0, 4'd3, 8'd5, 0, 0, 0);
        do_write(4'd3, 8'd1, 4'd3, 8'd2, 1, 0, 0);
        do_write(4'd3, 8'd2, 4'd3, 8'd7, 0, 1, 0);
        do_write(4'd3, 8'd3, 4'd3, 8'd9, 1, 1, 0);
        rd_check(12'h300, 32'h0000_0305, "R2");
        rd_check(12'h301, 32'h0001_0302, "R2");
        rd_check(12'h302, 32'h0002_0307, "R2");
        rd_check(12'h303, 32'h0003_0309, "R2");

        // R3 rejected writes and foreign reads
        cmp_tag = "R3";
        do_write(4'd3, 8'd0, 4'd2, 8'd9, 1, 1, 1);
        rd_check(12'h300, 32'h0000_0305, "R3");
        do_write(4'd5, 8'd0, 4'd3, 8'd9, 1, 1, 1);
        rd_check(12'h300, 32'h0000_0305, "R3");
        do_write(4'd3, 8'd4, 4'd3, 8'd9, 1, 1, 1);
        rd_check(12'h304, 32'h0, "R3");
        rd_check(12'h500, 32'h0, "R3");

        // R4 level mode
        cmp_tag = "R4";
        set_in(5, 1); bit_check(0, 1, "R4");
        set_in(2, 1); bit_check(1, 0, "R4");
        set_in(5, 0); bit_check(0, 0, "R4");
        set_in(2, 0); bit_check(1, 1, "R4");
        do_write(4'd3, 8'd0, 4'd3, 8'd20, 0, 0, 0);
        set_in(0, 1); bit_check(0, 0, "R4");
        do_write(4'd3, 8'd0, 4'd3, 8'd20, 1, 0, 0);
        bit_check(0, 1, "R4");
        set_in(0, 0);
        do_write(4'd3, 8'd0, 4'd3, 8'd5, 0, 0, 0);
        repeat (6) @(negedge cclk);

        // R5 single pulse of two cycles, long hold
        cmp_tag = "R5";
        fork
            set_in(7, 1);
            width_check(2, 12, 2, "R5");
        join
        set_in(7, 0);
        repeat (6) @(negedge cclk);

        // R9 falling edges
        cmp_tag = "R9";
        fork
            set_in(9, 1);
            width_check(3, 10, 0, "R9");
        join
        fork
            set_in(9, 0);
            width_check(3, 10, 2, "R9");
        join

        // R6 restart
        cmp_tag = "R6";
        fork
            begin
                set_in(7, 1);
                set_in(7, 0);
                set_in(7, 1);
            end
            width_check(2, 12, 4, "R6");
        join
        set_in(7, 0);
        repeat (6) @(negedge cclk);

        // R7 freeze-only write
        cmp_tag = "R7";
        do_frz(4'd3, 8'd1, 1);
        rd_check(12'h301, 32'h0005_0302, "R7");
        do_frz(4'd2, 8'd2, 1);
        rd_check(12'h302, 32'h0002_0307, "R7");

        // R8 debug freeze
        cmp_tag = "R8";
        set_in(5, 1);
        bit_check(1, 1, "R8");
        @(negedge clk); #1 dbg_halt = 1'b1;
        bit_check(1, 0, "R8");
        bit_check(0, 1, "R8");
        repeat (4) @(negedge cclk);
        @(negedge clk); #1 dbg_halt = 1'b0;
        bit_check(1, 1, "R8");
        do_frz(4'd3, 8'd1, 0);
        @(negedge clk); #1 dbg_halt = 1'b1;
        bit_check(1, 1, "R8");
        @(negedge clk); #1 dbg_halt = 1'b0;
        repeat (4) @(negedge cclk);

        run_cmp = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule